// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Monitor

This block sits beside the memory port of a time-sliced pipeline shared by several hardware threads. It watches every access the pipeline issues and keeps one reservation per thread, so that software can build atomic read-modify-write sequences from two single-cycle operations. A load-linked access opens the reservation. A later store-conditional succeeds only if nothing has broken that reservation in the meantime. Addresses are grouped into coarse 64-byte blocks for this purpose.

A reservation is opened by a load-linked access, which records the thread's block. It is cancelled by a write from a different thread into that block, by a trap taken by the owning thread, or by the thread's own next store-conditional. The block gates the memory write enable, so a failing store-conditional never reaches memory. It also returns a success bit, which the register file turns into a nonzero or zero value that a branch-if-zero retry loop can test. Accesses arrive one per cycle, so cycle order is issue order.

Top module: `llsc_monitor`

## Requirements
- R1: After a synchronous reset no thread holds a reservation: `mem_we`, `sc_done` and `sc_pass` are 0, and a store-conditional issued before any load-linked fails.
- R2: A load-linked (`acc_kind` = 2'b10) records the accessed block for the issuing thread and sets its reservation. A store-conditional that follows immediately from the same thread in the same block succeeds.
- R3: A store-conditional (`acc_kind` = 2'b11) succeeds only if the issuing thread holds a reservation whose block equals `acc_addr[ADDR_W-1:6]`. A failing one leaves `mem_we` low.
- R4: One cycle after each store-conditional, `sc_done` is 1 for one cycle and `sc_pass` gives the outcome: 1 for success and 0 for failure. `mem_we` equals `sc_pass` in that cycle.
- R5: A plain store (`acc_kind` = 2'b01) by another thread inside a reserved block clears that reservation. A store to a different block, a store by the owning thread, or a load (2'b00) leaves the reservation intact.
- R6: `trap_valid` with `trap_tid` clears that thread's reservation only, and takes priority over a load-linked issued by that thread in the same cycle.
- R7: A second load-linked by a thread replaces its earlier reservation. A store-conditional to the old block then fails.
- R8: Every store-conditional clears the issuing thread's reservation, whether it passes or fails.
- R9: A successful store-conditional clears the other threads' reservations on the same block. A failed one clears no other thread's reservation.
- R10: A plain store always raises `mem_we` one cycle later. Loads and load-linked accesses never raise `mem_we` or `sc_done`.
- R11: Reservations of different threads are independent and coexist, on the same block or on different blocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_tid | input | TID_W | Issuing thread |
| acc_kind | input | 2 | 00 load, 01 store, 10 load-linked, 11 store-conditional |
| acc_addr | input | ADDR_W | Byte address of the access |
| trap_valid | input | 1 | A thread takes an interrupt or exception this cycle |
| trap_tid | input | TID_W | Thread taking the trap |
| mem_we | output | 1 | Registered write enable to memory for the previous access |
| sc_done | output | 1 | Registered: the previous access was a store-conditional |
| sc_pass | output | 1 | Registered success bit of that store-conditional |

## Verification
The assertions assume that at most one access arrives per cycle, that `acc_tid` and `trap_tid` always name an existing thread, and that inputs are stable around the rising edge. The bench changes inputs only on the falling edge. It issues every access through a single task that presents one access per cycle with thread numbers below the thread count, and raises a trap only together with a legal thread number.

// File: rtl/llsc_pkg.sv
package llsc_pkg;
  typedef enum logic [1:0] {
    ACC_LOAD  = 2'b00,
    ACC_STORE = 2'b01,
    ACC_LINK  = 2'b10,
    ACC_COND  = 2'b11
  } acc_kind_e;
endpackage

// File: rtl/llsc_resv_slot.sv
// One thread's reservation: a flag plus the reserved block tag.
module llsc_resv_slot
  import llsc_pkg::*;
#(
  parameter int TID_W   = 2,
  parameter int TAG_W   = 26,
  parameter int SLOT_ID = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             acc_valid,
  input  logic [TID_W-1:0] acc_tid,
  input  logic [1:0]       acc_kind,
  input  logic [TAG_W-1:0] acc_tag,
  input  logic             cond_win,
  input  logic             trap_valid,
  input  logic [TID_W-1:0] trap_tid,
  output logic             hit
);
  logic             held_q;
  logic [TAG_W-1:0] tag_q;
  logic             own, do_link, own_cond, foreign_wr, trapped;

  assign hit        = held_q && (tag_q == acc_tag);
  assign own        = acc_valid && (acc_tid == TID_W'(SLOT_ID));
  assign do_link    = own && (acc_kind == ACC_LINK);
  assign own_cond   = own && (acc_kind == ACC_COND);
  assign foreign_wr = acc_valid && !own && hit &&
                      ((acc_kind == ACC_STORE) || ((acc_kind == ACC_COND) && cond_win));
  assign trapped    = trap_valid && (trap_tid == TID_W'(SLOT_ID));

  always_ff @(posedge clk) begin
    if (rst)                         held_q <= 1'b0;
    else if (trapped)                held_q <= 1'b0;
    else if (do_link)                held_q <= 1'b1;
    else if (own_cond || foreign_wr) held_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (do_link) tag_q <= acc_tag;
  end
endmodule

// File: rtl/llsc_cond_judge.sv
// Decides the store-conditional outcome and the raw write request.
module llsc_cond_judge
  import llsc_pkg::*;
#(
  parameter int NUM_THREADS = 4,
  parameter int TID_W       = 2
) (
  input  logic                   acc_valid,
  input  logic [TID_W-1:0]       acc_tid,
  input  logic [1:0]             acc_kind,
  input  logic [NUM_THREADS-1:0] hit_vec,
  output logic                   cond_win,
  output logic                   is_cond,
  output logic                   wr_req
);
  logic own_hit;

  always_comb begin
    own_hit = 1'b0;
    for (int i = 0; i < NUM_THREADS; i++)
      if (acc_tid == TID_W'(i)) own_hit = hit_vec[i];
  end

  assign is_cond  = acc_valid && (acc_kind == ACC_COND);
  assign cond_win = is_cond && own_hit;
  assign wr_req   = (acc_valid && (acc_kind == ACC_STORE)) || cond_win;
endmodule

// File: rtl/llsc_monitor.sv
module llsc_monitor
  import llsc_pkg::*;
#(
  parameter int NUM_THREADS = 4,
  parameter int ADDR_W      = 32,
  parameter int BLOCK_BYTES = 64,
  localparam int TID_W      = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1,
  localparam int OFFS_W     = $clog2(BLOCK_BYTES),
  localparam int TAG_W      = ADDR_W - OFFS_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_valid,
  input  logic [TID_W-1:0]  acc_tid,
  input  logic [1:0]        acc_kind,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              trap_valid,
  input  logic [TID_W-1:0]  trap_tid,
  output logic              mem_we,
  output logic              sc_done,
  output logic              sc_pass
);
  logic [TAG_W-1:0]       acc_tag;
  logic [NUM_THREADS-1:0] hit_vec;
  logic                   cond_win, is_cond, wr_req;

  assign acc_tag = acc_addr[ADDR_W-1:OFFS_W];

  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_slot
    llsc_resv_slot #(.TID_W(TID_W), .TAG_W(TAG_W), .SLOT_ID(t)) u_slot (
      .clk(clk), .rst(rst),
      .acc_valid(acc_valid), .acc_tid(acc_tid), .acc_kind(acc_kind),
      .acc_tag(acc_tag), .cond_win(cond_win),
      .trap_valid(trap_valid), .trap_tid(trap_tid),
      .hit(hit_vec[t])
    );
  end

  llsc_cond_judge #(.NUM_THREADS(NUM_THREADS), .TID_W(TID_W)) u_judge (
    .acc_valid(acc_valid), .acc_tid(acc_tid), .acc_kind(acc_kind),
    .hit_vec(hit_vec), .cond_win(cond_win), .is_cond(is_cond), .wr_req(wr_req)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_we  <= 1'b0;
      sc_done <= 1'b0;
      sc_pass <= 1'b0;
    end else begin
      mem_we  <= wr_req;
      sc_done <= is_cond;
      sc_pass <= cond_win;
    end
  end
endmodule

// File: rtl/llsc_monitor_chk.sv
module llsc_monitor_chk #(
  parameter int TID_W  = 2,
  parameter int ADDR_W = 32,
  parameter int OFFS_W = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              acc_valid,
  input logic [TID_W-1:0]  acc_tid,
  input logic [1:0]        acc_kind,
  input logic [ADDR_W-1:0] acc_addr,
  input logic              trap_valid,
  input logic [TID_W-1:0]  trap_tid,
  input logic              mem_we,
  input logic              sc_done,
  input logic              sc_pass
);
  // R1: outputs idle in the cycle after reset
  a_r1_idle_after_reset: assert property (@(posedge clk)
    $past(rst) |-> (!mem_we && !sc_done && !sc_pass));

  // R4: every store-conditional reports one cycle later
  a_r4_cond_reports: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && acc_kind == 2'b11) |=> sc_done);

  // R3: a failed store-conditional never writes memory
  a_r3_fail_no_write: assert property (@(posedge clk) disable iff (rst)
    (sc_done && !sc_pass) |-> !mem_we);

  // R10: plain stores always write; loads and links never do
  a_r10_store_writes: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && acc_kind == 2'b01) |=> (mem_we && !sc_done));
  a_r10_read_no_write: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && !acc_kind[0]) |=> (!mem_we && !sc_done));

  // R2: link followed at once by a same-block conditional from the same thread passes
  a_r2_link_then_cond: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && acc_kind == 2'b10 && !(trap_valid && trap_tid == acc_tid)) ##1
    (acc_valid && acc_kind == 2'b11 && acc_tid == $past(acc_tid) &&
     acc_addr[ADDR_W-1:OFFS_W] == $past(acc_addr[ADDR_W-1:OFFS_W]))
    |=> sc_pass);

  // R8: back-to-back conditionals from one thread: the second fails
  a_r8_cond_twice_fails: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && acc_kind == 2'b11) ##1
    (acc_valid && acc_kind == 2'b11 && acc_tid == $past(acc_tid))
    |=> !sc_pass);
endmodule

bind llsc_monitor llsc_monitor_chk #(.TID_W(TID_W), .ADDR_W(ADDR_W), .OFFS_W(OFFS_W)) u_chk (
  .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_tid(acc_tid),
  .acc_kind(acc_kind), .acc_addr(acc_addr), .trap_valid(trap_valid),
  .trap_tid(trap_tid), .mem_we(mem_we), .sc_done(sc_done), .sc_pass(sc_pass)
);

// File: tb/tb_llsc_monitor.sv
`timescale 1ns/1ps
module tb_llsc_monitor;
  localparam int N  = 4;
  localparam int TW = 2;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          acc_valid = 1'b0;
  logic [TW-1:0] acc_tid = '0;
  logic [1:0]    acc_kind = 2'b00;
  logic [AW-1:0] acc_addr = '0;
  logic          trap_valid = 1'b0;
  logic [TW-1:0] trap_tid = '0;
  logic          mem_we, sc_done, sc_pass;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  llsc_monitor #(.NUM_THREADS(N), .ADDR_W(AW), .BLOCK_BYTES(64)) dut (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_tid(acc_tid),
    .acc_kind(acc_kind), .acc_addr(acc_addr), .trap_valid(trap_valid),
    .trap_tid(trap_tid), .mem_we(mem_we), .sc_done(sc_done), .sc_pass(sc_pass)
  );

  localparam logic [1:0] K_LD = 2'b00, K_ST = 2'b01, K_LL = 2'b10, K_SC = 2'b11;

  // compare {mem_we, sc_done, sc_pass}
  task automatic check_out(input string req, input logic [2:0] exp);
    logic [2:0] act;
    act = {mem_we, sc_done, sc_pass};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: {we,done,pass} actual=%b expected=%b", req, act, exp);
    end
  endtask

  // present one access (optionally with a trap) and sample its registered result
  task automatic acc(input int tid, input logic [1:0] kind, input logic [AW-1:0] addr,
                     input bit tv = 0, input int tt = 0, input bit av = 1);
    @(negedge clk);
    acc_valid  = av;
    acc_tid    = TW'(tid);
    acc_kind   = kind;
    acc_addr   = addr;
    trap_valid = tv;
    trap_tid   = TW'(tt);
    @(posedge clk);
    #1;
    acc_valid  = 1'b0;
    trap_valid = 1'b0;
  endtask

  task automatic cond(input int tid, input logic [AW-1:0] addr, input bit pass, input string req);
    acc(tid, K_SC, addr);
    check_out(req, {pass, 1'b1, pass});
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #1 check_out("R1 outputs in reset", 3'b000);
    @(negedge clk) rst = 1'b0;
    @(posedge clk); #1 check_out("R1 outputs after reset", 3'b000);
    cond(0, 32'h0000_0100, 0, "R1 cond without link");
  endtask

  task automatic t_link_pass;
    acc(1, K_LL, 32'h0000_1000);
    check_out("R10 link no write", 3'b000);
    cond(1, 32'h0000_1010, 1, "R2 R3 cond same block");
    acc(1, K_LL, 32'h0000_1000);
    cond(1, 32'h0000_1040, 0, "R3 cond other block");
  endtask

  task automatic t_cond_clears;
    acc(2, K_LL, 32'h0000_2000);
    cond(2, 32'h0000_2000, 1, "R8 first cond");
    cond(2, 32'h0000_2000, 0, "R8 second cond fails");
    acc(2, K_LL, 32'h0000_2000);
    cond(2, 32'h0000_2400, 0, "R8 failing cond");
    cond(2, 32'h0000_2000, 0, "R8 flag cleared by failed cond");
  endtask

  task automatic t_stores;
    acc(0, K_LL, 32'h0000_3000);
    acc(1, K_ST, 32'h0000_3100);
    check_out("R10 store writes", 3'b100);
    cond(0, 32'h0000_3000, 1, "R5 store elsewhere keeps");
    acc(0, K_LL, 32'h0000_3000);
    acc(1, K_ST, 32'h0000_303C);
    cond(0, 32'h0000_3000, 0, "R5 foreign store kills");
    acc(0, K_LL, 32'h0000_3000);
    acc(0, K_ST, 32'h0000_3004);
    cond(0, 32'h0000_3000, 1, "R5 own store keeps");
    acc(1, K_LL, 32'h0000_B000);
    acc(2, K_LD, 32'h0000_B000);
    check_out("R10 load no write", 3'b000);
    cond(1, 32'h0000_B000, 1, "R5 load keeps");
  endtask

  task automatic t_trap;
    acc(0, K_LL, 32'h0000_4000);
    acc(1, K_LL, 32'h0000_5000);
    acc(0, K_LD, 32'h0, 1, 0, 0);
    cond(0, 32'h0000_4000, 0, "R6 trapped thread fails");
    cond(1, 32'h0000_5000, 1, "R6 R11 other thread keeps");
    acc(3, K_LL, 32'h0000_5800, 1, 3);
    cond(3, 32'h0000_5800, 0, "R6 trap beats link");
  endtask

  task automatic t_relink;
    acc(3, K_LL, 32'h0000_6000);
    acc(3, K_LL, 32'h0000_7000);
    cond(3, 32'h0000_6000, 0, "R7 old block fails");
    acc(3, K_LL, 32'h0000_6000);
    acc(3, K_LL, 32'h0000_7000);
    cond(3, 32'h0000_7000, 1, "R7 new block passes");
  endtask

  task automatic t_race;
    acc(0, K_LL, 32'h0000_8000);
    acc(1, K_LL, 32'h0000_8020);
    cond(1, 32'h0000_8000, 1, "R9 R11 first winner");
    cond(0, 32'h0000_8000, 0, "R9 loser fails");
    acc(0, K_LL, 32'h0000_9000);
    acc(2, K_LL, 32'h0000_A000);
    cond(2, 32'h0000_9000, 0, "R9 failing cond");
    cond(0, 32'h0000_9000, 1, "R9 failed cond does not kill");
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    t_reset();
    t_link_pass();
    t_cond_clears();
    t_stores();
    t_trap();
    t_relink();
    t_race();
    repeat (2) @(posedge clk);
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end
endmodule